// File: doc/BRIEF.md
# Auxiliary Memory DMA Register Front End

This block is the register face of a DMA engine that copies data between main memory and an auxiliary memory. It holds three 32-bit values: a main-memory address, an auxiliary-memory address and a byte count. Each value is reached over a 16-bit register bus as a separate upper half and lower half. Three 16-bit configuration words (info, mode and refresh) sit in the same window and simply keep whatever is written to them. The data mover lives outside this block. It sees only a one-cycle start pulse and returns a busy level.

Addresses and counts are forced to 32-byte granularity. When a lower half is written, its five least significant bits are cleared. Writing the lower half of the count arms the transfer. A 32-bit bus access is treated as two half-word accesses in the same cycle: first the upper half at the word offset, then the lower half at offset+2. A full-width count write therefore ends by launching the transfer. Reads return stored values one cycle later and change nothing.

Top module: `auxdma_regs`

## Requirements
- R1: A synchronous active-high `rst` clears every stored register to zero, and holds `dma_start`, `dma_err` and `rd_valid` low.
- R2: The upper halves of the main address (offset 0x000) and the auxiliary address (0x004) store the written 16 bits unchanged. The lower halves (0x002 and 0x006) store the written data ANDed with 0xFFE0.
- R3: A half-word write to the count's lower half (0x00A) stores the data with bits 4:0 cleared and keeps the stored upper 16 bits. A write to the count's upper half (0x008) stores the value and raises no start.
- R4: Every accepted write to the count's lower half while the mover is idle produces `dma_start` high for exactly one cycle, in the cycle after the write.
- R5: A count-lower write that arrives while `dma_busy` is high, or while the previous start pulse is still on the port, raises no start pulse. The count register is still updated, and `dma_err` is set. `dma_err` stays set until reset.
- R6: info (0x010), mode (0x012) and refresh (0x014) are plain 16-bit storage: a read returns exactly the last written value, with no masking.
- R7: A 32-bit write (`bus_word`=1) at word offset i, with `bus_addr[1:0]` ignored, writes `bus_wdata[31:16]` to offset i and then `bus_wdata[15:0]` to i+2, with each half's own rules. A 32-bit count write at 0x008 starts the DMA once.
- R8: A read asserts `rd_valid` one cycle later. A 32-bit read at word offset i returns {reg(i), reg(i+2)}. A 16-bit read returns the register zero-extended in `rd_data[15:0]`.
- R9: An access acts only when `bus_addr[31:12]` equals `BASE[31:12]`. Accesses outside the window write nothing and give no `rd_valid`. Unmapped offsets inside the window read as zero and ignore writes.
- R10: Reads have no side effects: reading any register, including the count's lower half, changes no register and raises no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_word | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_wdata | input | 32 | Write data; a 16-bit access uses bits 15:0 |
| rd_valid | output | 1 | Read data valid, one cycle after `bus_rd` |
| rd_data | output | 32 | Read data |
| dma_busy | input | 1 | Mover is running |
| dma_start | output | 1 | One-cycle transfer launch |
| dma_err | output | 1 | Sticky flag: a start was requested while busy |

## Verification
Two functions can fall into the same cycle: a new count-lower write, and the launch pulse of the previous one. The bench provokes this with two back-to-back count-lower writes with no idle cycle between them, and with a count write while `dma_busy` is held high. In both cases it expects a single pulse, `dma_err` set, and the count holding the second value. A scoreboard queues the expected value of every read and compares it when `rd_valid` returns.

// File: rtl/auxdma_pkg.sv
package auxdma_pkg;

    localparam int HW_W  = 16;          // bus half-word width
    localparam int WD_W  = 2 * HW_W;    // full register width
    localparam int WIN_W = 12;          // offset bits inside the window

    localparam logic [WIN_W-1:0] OFS_MAIN_HI = 12'h000;
    localparam logic [WIN_W-1:0] OFS_MAIN_LO = 12'h002;
    localparam logic [WIN_W-1:0] OFS_AUX_HI  = 12'h004;
    localparam logic [WIN_W-1:0] OFS_AUX_LO  = 12'h006;
    localparam logic [WIN_W-1:0] OFS_CNT_HI  = 12'h008;
    localparam logic [WIN_W-1:0] OFS_CNT_LO  = 12'h00A;
    localparam logic [WIN_W-1:0] OFS_INFO    = 12'h010;
    localparam logic [WIN_W-1:0] OFS_MODE    = 12'h012;
    localparam logic [WIN_W-1:0] OFS_REFR    = 12'h014;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_MAIN_HI, SEL_MAIN_LO, SEL_AUX_HI, SEL_AUX_LO,
        SEL_CNT_HI, SEL_CNT_LO, SEL_INFO, SEL_MODE, SEL_REFR
    } reg_sel_e;

    typedef struct packed {
        logic [WD_W-1:0] main_addr;
        logic [WD_W-1:0] aux_addr;
        logic [WD_W-1:0] cnt;
        logic [HW_W-1:0] info;
        logic [HW_W-1:0] mode;
        logic [HW_W-1:0] refr;
    } regs_t;

    function automatic logic [HW_W-1:0] read_half(regs_t r, reg_sel_e s);
        case (s)
            SEL_MAIN_HI: return r.main_addr[WD_W-1:HW_W];
            SEL_MAIN_LO: return r.main_addr[HW_W-1:0];
            SEL_AUX_HI:  return r.aux_addr[WD_W-1:HW_W];
            SEL_AUX_LO:  return r.aux_addr[HW_W-1:0];
            SEL_CNT_HI:  return r.cnt[WD_W-1:HW_W];
            SEL_CNT_LO:  return r.cnt[HW_W-1:0];
            SEL_INFO:    return r.info;
            SEL_MODE:    return r.mode;
            SEL_REFR:    return r.refr;
            default:     return '0;
        endcase
    endfunction

endpackage

// File: rtl/auxdma_decode.sv
module auxdma_decode
    import auxdma_pkg::*;
(
    input  logic [WIN_W-1:0] ofs,
    output reg_sel_e         sel
);
    always_comb begin
        case (ofs)
            OFS_MAIN_HI: sel = SEL_MAIN_HI;
            OFS_MAIN_LO: sel = SEL_MAIN_LO;
            OFS_AUX_HI:  sel = SEL_AUX_HI;
            OFS_AUX_LO:  sel = SEL_AUX_LO;
            OFS_CNT_HI:  sel = SEL_CNT_HI;
            OFS_CNT_LO:  sel = SEL_CNT_LO;
            OFS_INFO:    sel = SEL_INFO;
            OFS_MODE:    sel = SEL_MODE;
            OFS_REFR:    sel = SEL_REFR;
            default:     sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/auxdma_start_ctl.sv
module auxdma_start_ctl (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic busy_i,
    output logic start_o,
    output logic err_o
);
    typedef struct packed {
        logic start;
        logic err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic busy;

    always_comb begin
        busy        = busy_i | ctl_q.start;
        ctl_d.start = req & ~busy;
        ctl_d.err   = ctl_q.err | (req & busy);
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign start_o = ctl_q.start;
    assign err_o   = ctl_q.err;

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) start_o |=> !start_o); // R4
    AST_IDLE_REQ_STARTS: assert property (@(posedge clk) disable iff (rst) (req && !busy_i && !start_o) |=> start_o); // R4
    AST_BUSY_BLOCKS:     assert property (@(posedge clk) disable iff (rst) (req && (busy_i || start_o)) |=> (!start_o && err_o)); // R5
    AST_ERR_STICKY:      assert property (@(posedge clk) disable iff (rst) err_o |=> err_o); // R5
endmodule

// File: rtl/auxdma_regs.sv
module auxdma_regs
    import auxdma_pkg::*;
#(
    parameter logic [31:0] BASE       = 32'h0000_5000,
    parameter int          ALIGN_BITS = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [31:0]     bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic            bus_word,
    input  logic [WD_W-1:0] bus_wdata,
    output logic            rd_valid,
    output logic [WD_W-1:0] rd_data,
    input  logic            dma_busy,
    output logic            dma_start,
    output logic            dma_err
);
    localparam int              LANES      = 2;
    localparam logic [HW_W-1:0] ALIGN_MASK = ~((HW_W'(1) << ALIGN_BITS) - HW_W'(1));

    typedef struct packed {
        regs_t           regs;
        logic            rd_valid;
        logic [WD_W-1:0] rd_data;
    } state_t;

    state_t   st_d, st_q;
    logic     hit;
    logic     start_req;
    logic     [WIN_W-1:0] lane_ofs  [LANES];
    reg_sel_e             lane_sel  [LANES];
    logic     [HW_W-1:0]  lane_data [LANES];
    logic                 lane_act  [LANES];

    // Lane 0 is the upper-half access (or the only one), lane 1 the lower half at +2.
    always_comb begin
        lane_ofs[0]  = bus_word ? {bus_addr[WIN_W-1:2], 2'b00} : bus_addr[WIN_W-1:0];
        lane_ofs[1]  = lane_ofs[0] + WIN_W'(2);
        lane_data[0] = bus_word ? bus_wdata[WD_W-1:HW_W] : bus_wdata[HW_W-1:0];
        lane_data[1] = bus_wdata[HW_W-1:0];
        lane_act[0]  = 1'b1;
        lane_act[1]  = bus_word;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        auxdma_decode u_dec (
            .ofs (lane_ofs[g]),
            .sel (lane_sel[g])
        );
    end

    function automatic regs_t apply_write(regs_t r, reg_sel_e s, logic [HW_W-1:0] v);
        regs_t n = r;
        case (s)
            SEL_MAIN_HI: n.main_addr[WD_W-1:HW_W] = v;
            SEL_MAIN_LO: n.main_addr[HW_W-1:0]    = v & ALIGN_MASK;
            SEL_AUX_HI:  n.aux_addr[WD_W-1:HW_W]  = v;
            SEL_AUX_LO:  n.aux_addr[HW_W-1:0]     = v & ALIGN_MASK;
            SEL_CNT_HI:  n.cnt[WD_W-1:HW_W]       = v;
            SEL_CNT_LO:  n.cnt[HW_W-1:0]          = v & ALIGN_MASK;
            SEL_INFO:    n.info                   = v;
            SEL_MODE:    n.mode                   = v;
            SEL_REFR:    n.refr                   = v;
            default:     n = r;
        endcase
        return n;
    endfunction

    always_comb begin
        st_d      = st_q;
        hit       = (bus_addr[31:WIN_W] == BASE[31:WIN_W]);
        start_req = 1'b0;
        // Writes: upper-half lane first, then lower-half lane, in that order.
        for (int i = 0; i < LANES; i++) begin
            if (hit && bus_wr && lane_act[i]) begin
                st_d.regs = apply_write(st_d.regs, lane_sel[i], lane_data[i]);
                if (lane_sel[i] == SEL_CNT_LO) start_req = 1'b1;
            end
        end
        // Reads: sampled from the registered state, one cycle of latency.
        st_d.rd_valid = hit && bus_rd;
        if (hit && bus_rd)
            st_d.rd_data = bus_word ? {read_half(st_q.regs, lane_sel[0]), read_half(st_q.regs, lane_sel[1])}
                                    : {{HW_W{1'b0}}, read_half(st_q.regs, lane_sel[0])};
        else
            st_d.rd_data = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    auxdma_start_ctl u_start (
        .clk     (clk),
        .rst     (rst),
        .req     (start_req),
        .busy_i  (dma_busy),
        .start_o (dma_start),
        .err_o   (dma_err)
    );

    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_data;

    AST_RESET_CLEARS:  assert property (@(posedge clk) rst |=> (st_q.regs == '0 && !rd_valid && !dma_start && !dma_err)); // R1
    AST_MAIN_ALIGNED:  assert property (@(posedge clk) disable iff (rst) st_q.regs.main_addr[ALIGN_BITS-1:0] == '0 && st_q.regs.aux_addr[ALIGN_BITS-1:0] == '0); // R2
    AST_CNT_ALIGNED:   assert property (@(posedge clk) disable iff (rst) st_q.regs.cnt[ALIGN_BITS-1:0] == '0); // R3
    AST_CNT_HI_QUIET:  assert property (@(posedge clk) disable iff (rst) (hit && bus_wr && !bus_word && lane_sel[0] == SEL_CNT_HI) |=> !dma_start); // R3
    AST_RD_LATENCY:    assert property (@(posedge clk) disable iff (rst) (hit && bus_rd) |=> rd_valid); // R8
    AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (rst) (!hit) |=> (!rd_valid && st_q.regs == $past(st_q.regs))); // R9
    AST_READ_NO_SIDE:  assert property (@(posedge clk) disable iff (rst) (!bus_wr) |=> (st_q.regs == $past(st_q.regs) && !dma_start)); // R10
endmodule

// File: tb/auxdma_regs_tb.sv
`timescale 1ns/1ps
module auxdma_regs_tb;
    localparam logic [31:0] BASE = 32'h0000_5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_word = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        dma_busy = 1'b0;
    logic        rd_valid, dma_start, dma_err;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    logic        done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    auxdma_regs #(.BASE(BASE), .ALIGN_BITS(5)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .dma_busy(dma_busy), .dma_start(dma_start), .dma_err(dma_err)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Driver: one write, returns on the negedge after the registering edge.
    task automatic wr(logic word, logic [11:0] ofs, logic [31:0] data, logic [31:0] base = BASE);
        @(negedge clk);
        bus_addr = base | {20'h0, ofs}; bus_word = word; bus_wdata = data; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: one read, expected value pushed to the scoreboard.
    task automatic rd(logic word, logic [11:0] ofs, logic [31:0] exp, string req);
        @(negedge clk);
        bus_addr = BASE | {20'h0, ofs}; bus_word = word; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(req);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor: pops the scoreboard whenever read data comes back.
    always @(negedge clk) begin
        if (rd_valid && !rst) begin
            if (exp_q.size() == 0) check("R8 unexpected rd_valid", 32'd1, 32'd0);
            else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 dma_start", {31'h0, dma_start}, 32'h0);
        check("R1 dma_err", {31'h0, dma_err}, 32'h0);
        check("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
        rd(1'b1, 12'h000, 32'h0, "R1 main");
        rd(1'b1, 12'h008, 32'h0, "R1 cnt");
        rd(1'b0, 12'h010, 32'h0, "R1 info");

        // R2 address halves
        wr(1'b0, 12'h000, 32'h0000_DEAD);
        wr(1'b0, 12'h002, 32'h0000_BEEF);
        rd(1'b1, 12'h000, 32'hDEAD_BEE0, "R2 main word");
        wr(1'b0, 12'h004, 32'h0000_1234);
        wr(1'b0, 12'h006, 32'h0000_001F);
        rd(1'b0, 12'h006, 32'h0000_0000, "R2 aux lo masked");
        rd(1'b0, 12'h004, 32'h0000_1234, "R2 aux hi");

        // R3 / R4 count halves and start
        wr(1'b0, 12'h008, 32'h0000_ABCD);
        check("R3 hi write no start", {31'h0, dma_start}, 32'h0);
        wr(1'b0, 12'h00A, 32'h0000_FFFF);
        check("R4 start pulse", {31'h0, dma_start}, 32'h1);
        @(negedge clk);
        check("R4 pulse one cycle", {31'h0, dma_start}, 32'h0);
        rd(1'b1, 12'h008, 32'hABCD_FFE0, "R3 cnt word");

        // R6 plain storage
        wr(1'b0, 12'h010, 32'h0000_A5A5);
        wr(1'b0, 12'h012, 32'h0000_0007);
        wr(1'b0, 12'h014, 32'h0000_009C);
        rd(1'b0, 12'h010, 32'h0000_A5A5, "R6 info");
        rd(1'b0, 12'h012, 32'h0000_0007, "R6 mode");
        rd(1'b0, 12'h014, 32'h0000_009C, "R6 refresh");

        // R7 word writes
        wr(1'b1, 12'h004, 32'h7654_3217);
        rd(1'b1, 12'h004, 32'h7654_3200, "R7 aux word");
        wr(1'b1, 12'h00B, 32'h0001_0047);
        check("R7 word count starts", {31'h0, dma_start}, 32'h1);
        rd(1'b1, 12'h008, 32'h0001_0040, "R7 cnt word");
        wr(1'b1, 12'h010, 32'h1111_2222);
        rd(1'b0, 12'h010, 32'h0000_1111, "R7 info from upper");
        rd(1'b0, 12'h012, 32'h0000_2222, "R7 mode from lower");

        // R9 window decode and unmapped offsets
        wr(1'b0, 12'h002, 32'h0000_FFFF, 32'h0000_6000);
        rd(1'b1, 12'h000, 32'hDEAD_BEE0, "R9 outside write ignored");
        @(negedge clk);
        bus_addr = 32'h0000_6000; bus_word = 1'b0; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R9 outside read no rd_valid", {31'h0, rd_valid}, 32'h0);
        wr(1'b0, 12'h00C, 32'h0000_5555);
        check("R9 unmapped write no start", {31'h0, dma_start}, 32'h0);
        rd(1'b0, 12'h00C, 32'h0, "R9 unmapped reads zero");
        rd(1'b1, 12'h008, 32'h0001_0040, "R9 cnt untouched");

        // R10 reads have no side effect
        rd(1'b0, 12'h00A, 32'h0000_0040, "R10 read cnt lo");
        check("R10 read no start", {31'h0, dma_start}, 32'h0);
        rd(1'b0, 12'h00A, 32'h0000_0040, "R10 cnt lo stable");

        // R5 start while mover busy
        dma_busy = 1'b1;
        wr(1'b0, 12'h00A, 32'h0000_0100);
        check("R5 busy no start", {31'h0, dma_start}, 32'h0);
        check("R5 err set", {31'h0, dma_err}, 32'h1);
        rd(1'b1, 12'h008, 32'h0001_0100, "R5 cnt still stored");
        dma_busy = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 err sticky", {31'h0, dma_err}, 32'h1);
        wr(1'b0, 12'h00A, 32'h0000_0020);
        check("R5 idle start after err", {31'h0, dma_start}, 32'h1);

        // R1 reset clears the sticky flag; R5 collision with own pulse
        do_reset();
        check("R1 err cleared", {31'h0, dma_err}, 32'h0);
        @(negedge clk);
        bus_addr = BASE | 32'h00A; bus_word = 1'b0; bus_wdata = 32'h0000_0040; bus_wr = 1'b1;
        @(negedge clk);
        check("R4 first of pair starts", {31'h0, dma_start}, 32'h1);
        bus_wdata = 32'h0000_0080;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R5 back-to-back no second pulse", {31'h0, dma_start}, 32'h0);
        check("R5 back-to-back err", {31'h0, dma_err}, 32'h1);
        rd(1'b1, 12'h008, 32'h0000_0080, "R5 cnt holds second value");

        repeat (3) @(negedge clk);
        check("R8 scoreboard drained", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule